// File: doc/BRIEF.md
# Status Register Write-Protection Controller

This block keeps the status byte of a serial flash device and rules on every write-type command that the serial front end decodes. The front end presents one command event per chip-select release: the opcode, the 24-bit address, the data byte that followed the opcode (used by the status write), and a flag saying whether the number of clocks seen was a whole number of bytes. The controller combines three guards. The first is the write-enable latch. The second is a lock on the status byte that depends on the write-protect pin. The third is a decoder of the protected address range. A command that passes all three guards produces a one-cycle start strobe, with an operation code and the array address, to the program/erase sequencer. A command that fails produces a one-cycle reject flag.

The behaviour is a two-state machine. `ST_IDLE` has a self-loop that handles enable, disable, non-write commands and rejected commands. The transition GO moves `ST_IDLE` to `ST_BUSY` when a write-type command is accepted. `ST_BUSY` has a self-loop that drops every command except read-status. The transition FINISH moves `ST_BUSY` back to `ST_IDLE` on the sequencer's done pulse, and also clears the write-enable latch. The default array is 256 KiB, made of four 64 KiB blocks.

Top module: `flash_wp_ctrl`

## Requirements
- R1: After reset the status byte is 00h, and both the start strobe and the reject flag are low.
- R2: Status byte layout: bit 0 is busy (WIP), bit 1 is the write-enable latch (WEL), bits 2..4 are protect bits BP0..BP2, bits 5 and 6 always read 0, and bit 7 is the status lock bit SRWD.
- R3: Opcode 06h sets WEL and opcode 04h clears it, with the effect visible one clock after the command event. Both act only while idle.
- R4: A write-type command (02h, 20h, D7h, D8h, C7h, 60h, 01h) is rejected when WEL is 0.
- R5: A status write (01h) copies data bits 7 and 4..2 into SRWD and BP2..BP0, and ignores data bits 6, 5, 1 and 0. It is rejected when SRWD is 1 and the write-protect input is low; every other combination of these two is accepted.
- R6: With BP1:BP0 = 00 nothing is protected, 01 protects the top quarter, 10 protects the top half, and 11 protects the whole array. BP2 does not change the range. A program or a sector/block erase whose address (low 18 bits) falls in the protected range is rejected.
- R7: A chip erase (C7h or 60h) is accepted only when BP2..BP0 are all 0.
- R8: A write-type command whose clock count is not a whole number of bytes is rejected.
- R9: While WIP is 1, opcode 05h is neither rejected nor acted on. Every other command, including 06h and 04h, is rejected and leaves the status byte unchanged.
- R10: An accepted write-type command raises the start strobe for exactly one cycle, one clock after the event, and sets WIP. The op-kind output is then 1 for program, 2 for sector erase, 3 for block erase, 4 for chip erase and 5 for status write. The address output carries the low 18 address bits with bits 23..18 forced to 0.
- R11: A done pulse while busy clears WIP and WEL in the next cycle. A done pulse while idle has no effect.
- R12: A rejected command raises the reject flag for exactly one cycle, one clock after the event, and leaves WEL, the BP bits and SRWD unchanged.
- R13: Opcodes 20h and D7h both mean sector erase, and C7h and 60h both mean chip erase. Block erase is D8h and page program is 02h. A non-write opcode such as 03h, issued while idle, neither starts nor rejects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_evt | input | 1 | One-cycle command event at chip-select release |
| cmd_opcode | input | 8 | Decoded opcode |
| cmd_addr | input | 24 | Address bytes of the command |
| cmd_data | input | 8 | First data byte (status write value) |
| cmd_whole | input | 1 | Clock count was a multiple of eight |
| wp_n | input | 1 | Write-protect pin level, low = protect |
| op_done | input | 1 | Completion pulse from the program/erase timer |
| status | output | 8 | Status byte as returned by read-status |
| op_start | output | 1 | One-cycle start strobe for the sequencer |
| op_kind | output | 3 | Kind of operation started |
| op_addr | output | 24 | Array address of the operation started |
| cmd_reject | output | 1 | One-cycle flag for a dropped command |

## Verification
The main sweep covers every value of the three protect bits, both SRWD values, both write-protect pin levels, WEL set or clear, and both whole-byte flags. Each of those combinations is crossed with each write-type opcode alias, one read opcode, and an address in each quarter of the array. This separates range decoding (quarter against BP1:BP0) from the chip-erase rule (any BP bit, BP2 included) and from the pin-dependent status lock. The addresses carry garbage in their unused top bits, and the status-write data carries inverted values and ones in the reserved positions, so both checks confirm that only the defined bits take effect. Directed sequences cover commands issued while busy, read-status issued while busy, a done pulse while idle, and enable followed by disable.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

    typedef enum logic [2:0] {
        K_NONE  = 3'd0,
        K_PROG  = 3'd1,
        K_SECT  = 3'd2,
        K_BLK   = 3'd3,
        K_CHIP  = 3'd4,
        K_WRSR  = 3'd5,
        K_WREN  = 3'd6,
        K_WRDI  = 3'd7
    } op_kind_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } wp_state_t;

    localparam logic [7:0] OPC_WREN   = 8'h06;
    localparam logic [7:0] OPC_WRDI   = 8'h04;
    localparam logic [7:0] OPC_RDSR   = 8'h05;
    localparam logic [7:0] OPC_WRSR   = 8'h01;
    localparam logic [7:0] OPC_PROG   = 8'h02;
    localparam logic [7:0] OPC_SECT_A = 8'h20;
    localparam logic [7:0] OPC_SECT_B = 8'hD7;
    localparam logic [7:0] OPC_BLK    = 8'hD8;
    localparam logic [7:0] OPC_CHIP_A = 8'hC7;
    localparam logic [7:0] OPC_CHIP_B = 8'h60;

endpackage

// File: rtl/wp_cmd_classify.sv
module wp_cmd_classify
    import flash_wp_pkg::*;
(
    input  logic [7:0] opcode,
    output op_kind_t   kind,
    output logic       is_rdsr,
    output logic       is_write
);

    always_comb begin
        kind = K_NONE;
        case (opcode)
            OPC_PROG:               kind = K_PROG;
            OPC_SECT_A, OPC_SECT_B: kind = K_SECT;
            OPC_BLK:                kind = K_BLK;
            OPC_CHIP_A, OPC_CHIP_B: kind = K_CHIP;
            OPC_WRSR:               kind = K_WRSR;
            OPC_WREN:               kind = K_WREN;
            OPC_WRDI:               kind = K_WRDI;
            default:                kind = K_NONE;
        endcase
    end

    assign is_rdsr  = (opcode == OPC_RDSR);
    assign is_write = (kind == K_PROG) || (kind == K_SECT) || (kind == K_BLK) ||
                      (kind == K_CHIP) || (kind == K_WRSR);

endmodule

// File: rtl/wp_range_check.sv
module wp_range_check #(
    parameter int ARRAY_ADDR_W = 18
) (
    input  logic [ARRAY_ADDR_W-1:0] addr,
    input  logic [2:0]              bp,
    output logic                    in_prot,
    output logic                    any_bp
);

    localparam int TOP = ARRAY_ADDR_W - 1;

    logic top_quarter;
    logic top_half;

    assign top_half    = addr[TOP];
    assign top_quarter = addr[TOP] & addr[TOP-1];

    always_comb begin
        unique case (bp[1:0])
            2'b00: in_prot = 1'b0;
            2'b01: in_prot = top_quarter;
            2'b10: in_prot = top_half;
            2'b11: in_prot = 1'b1;
            default: in_prot = 1'b0;
        endcase
    end

    assign any_bp = |bp;

endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
    import flash_wp_pkg::*;
#(
    parameter int CMD_ADDR_W   = 24,
    parameter int ARRAY_ADDR_W = 18
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_evt,
    input  logic [7:0]            cmd_opcode,
    input  logic [CMD_ADDR_W-1:0] cmd_addr,
    input  logic [7:0]            cmd_data,
    input  logic                  cmd_whole,
    input  logic                  wp_n,
    input  logic                  op_done,
    output logic [7:0]            status,
    output logic                  op_start,
    output logic [2:0]            op_kind,
    output logic [CMD_ADDR_W-1:0] op_addr,
    output logic                  cmd_reject
);

    localparam int PAD_W = CMD_ADDR_W - ARRAY_ADDR_W;

    wp_state_t state_q, state_nx;
    logic      wel_q, wel_nx;
    logic [2:0] bp_q, bp_nx;
    logic      srwd_q, srwd_nx;
    logic      go, drop;
    op_kind_t  kind;
    logic      is_rdsr, is_write;
    logic      in_prot, any_bp;
    logic      sr_locked, permit;
    logic [ARRAY_ADDR_W-1:0] arr_addr;
    logic      unused_bits;

    assign arr_addr    = cmd_addr[ARRAY_ADDR_W-1:0];
    assign unused_bits = ^{cmd_data[6:5], cmd_data[1:0], cmd_addr[CMD_ADDR_W-1:ARRAY_ADDR_W]};

    wp_cmd_classify u_cls (
        .opcode   (cmd_opcode),
        .kind     (kind),
        .is_rdsr  (is_rdsr),
        .is_write (is_write)
    );

    wp_range_check #(.ARRAY_ADDR_W(ARRAY_ADDR_W)) u_rng (
        .addr    (arr_addr),
        .bp      (bp_q),
        .in_prot (in_prot),
        .any_bp  (any_bp)
    );

    assign sr_locked = srwd_q & ~wp_n;

    always_comb begin
        permit = 1'b0;
        if (cmd_whole && wel_q) begin
            if (kind == K_WRSR)      permit = ~sr_locked;
            else if (kind == K_CHIP) permit = ~any_bp;
            else                     permit = ~in_prot;
        end
    end

    // next-state and decision logic
    always_comb begin
        state_nx = state_q;
        wel_nx   = wel_q;
        bp_nx    = bp_q;
        srwd_nx  = srwd_q;
        go       = 1'b0;
        drop     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_evt) begin
                    if (kind == K_WREN) begin
                        wel_nx = 1'b1;
                    end else if (kind == K_WRDI) begin
                        wel_nx = 1'b0;
                    end else if (is_write) begin
                        if (permit) begin
                            go       = 1'b1;
                            state_nx = ST_BUSY;          // GO
                            if (kind == K_WRSR) begin
                                srwd_nx = cmd_data[7];
                                bp_nx   = cmd_data[4:2];
                            end
                        end else begin
                            drop = 1'b1;
                        end
                    end
                end
            end
            ST_BUSY: begin
                if (cmd_evt && !is_rdsr) drop = 1'b1;
                if (op_done) begin
                    state_nx = ST_IDLE;                  // FINISH
                    wel_nx   = 1'b0;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wel_q   <= 1'b0;
            bp_q    <= 3'b000;
            srwd_q  <= 1'b0;
        end else begin
            state_q <= state_nx;
            wel_q   <= wel_nx;
            bp_q    <= bp_nx;
            srwd_q  <= srwd_nx;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_start   <= 1'b0;
            cmd_reject <= 1'b0;
            op_kind    <= K_NONE;
            op_addr    <= '0;
        end else begin
            op_start   <= go;
            cmd_reject <= drop;
            if (go) begin
                op_kind <= kind;
                op_addr <= {{PAD_W{1'b0}}, arr_addr};
            end
        end
    end

    assign status = {srwd_q, 2'b00, bp_q, wel_q, (state_q == ST_BUSY)};

    // R10: a started operation shows as busy
    a_r10_start_sets_wip: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> status[0]);

    // R4: a start needs the latch set in the cycle of the decision
    a_r4_start_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> $past(status[1]));

    // R9: nothing starts while a previous operation runs
    a_r9_no_start_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> !$past(status[0]));

    // R7: chip erase only with all protect bits clear
    a_r7_chip_bp_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && op_kind == 3'd4) |-> ($past(status[4:2]) == 3'b000));

    // R12: a command either starts or is rejected, never both
    a_r12_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_start && cmd_reject));

    // R11: done while busy clears busy and latch
    a_r11_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && status[0]) |=> (status[1:0] == 2'b00));

    // R5: locked status write leaves the protection bits alone
    a_r5_locked_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_evt && cmd_opcode == 8'h01 && status[7] && !wp_n) |=> $stable(status[7:2]));

endmodule

// File: tb/flash_wp_ctrl_tb.sv
`timescale 1ns/1ps
module flash_wp_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_evt = 1'b0;
    logic [7:0]  cmd_opcode = 8'h00;
    logic [23:0] cmd_addr = 24'h0;
    logic [7:0]  cmd_data = 8'h00;
    logic        cmd_whole = 1'b1;
    logic        wp_n = 1'b1;
    logic        op_done = 1'b0;
    logic [7:0]  status;
    logic        op_start;
    logic [2:0]  op_kind;
    logic [23:0] op_addr;
    logic        cmd_reject;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    flash_wp_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_evt(cmd_evt), .cmd_opcode(cmd_opcode),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_whole(cmd_whole),
        .wp_n(wp_n), .op_done(op_done), .status(status), .op_start(op_start),
        .op_kind(op_kind), .op_addr(op_addr), .cmd_reject(cmd_reject)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic issue(input logic [7:0] op, input logic [23:0] a,
                         input logic [7:0] d, input logic wh);
        @(negedge clk);
        cmd_evt = 1'b1; cmd_opcode = op; cmd_addr = a; cmd_data = d; cmd_whole = wh;
        @(negedge clk);
        cmd_evt = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
    endtask

    task automatic setup(input logic sr, input logic [2:0] b, input logic w);
        wp_n = 1'b1;
        issue(8'h06, 24'h0, 8'h00, 1'b1);
        issue(8'h01, 24'h0, {sr, 2'b00, b, 2'b00}, 1'b1);
        pulse_done();
        if (w) issue(8'h06, 24'h0, 8'h00, 1'b1);
        chk("R2 setup status", status, {sr, 2'b00, b, w, 1'b0});
    endtask

    function automatic logic [2:0] kind_of(input logic [7:0] op);
        case (op)
            8'h02: return 3'd1;
            8'h20, 8'hD7: return 3'd2;
            8'hD8: return 3'd3;
            8'hC7, 8'h60: return 3'd4;
            8'h01: return 3'd5;
            default: return 3'd0;
        endcase
    endfunction

    initial begin
        #800000;
        if (!finished) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] ops [8];
        ops[0] = 8'h02; ops[1] = 8'h20; ops[2] = 8'hD7; ops[3] = 8'hD8;
        ops[4] = 8'hC7; ops[5] = 8'h60; ops[6] = 8'h01; ops[7] = 8'h03;

        repeat (3) @(negedge clk);
        chk("R1 status in reset", status, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 status", status, 8'h00);
        chk("R1 start", op_start, 0);
        chk("R1 reject", cmd_reject, 0);

        // R3: enable then disable
        issue(8'h06, 24'h0, 8'h00, 1'b1);
        chk("R3 wren", status, 8'h02);
        issue(8'h04, 24'h0, 8'h00, 1'b1);
        chk("R3 wrdi", status, 8'h00);

        // R11: done while idle ignored
        issue(8'h06, 24'h0, 8'h00, 1'b1);
        pulse_done();
        chk("R11 idle done", status, 8'h02);

        // R9: busy behaviour
        issue(8'h02, 24'h001000, 8'h00, 1'b1);
        chk("R10 busy start", op_start, 1);
        @(negedge clk);
        chk("R10 start one cycle", op_start, 0);
        issue(8'h06, 24'h0, 8'h00, 1'b1);
        chk("R9 wren while busy rejected", cmd_reject, 1);
        chk("R9 status kept", status, 8'h03);
        issue(8'h04, 24'h0, 8'h00, 1'b1);
        chk("R9 wrdi while busy rejected", cmd_reject, 1);
        chk("R9 wel kept", status, 8'h03);
        issue(8'h05, 24'h0, 8'h00, 1'b1);
        chk("R9 rdsr not rejected", cmd_reject, 0);
        issue(8'h20, 24'h0, 8'h00, 1'b1);
        chk("R9 erase while busy rejected", cmd_reject, 1);
        chk("R9 no start while busy", op_start, 0);
        pulse_done();
        chk("R11 done clears", status, 8'h00);

        // exhaustive sweep
        for (int b = 0; b < 8; b++)
        for (int sr = 0; sr < 2; sr++)
        for (int wl = 0; wl < 2; wl++)
        for (int wp = 0; wp < 2; wp++)
        for (int oi = 0; oi < 8; oi++)
        for (int q = 0; q < 4; q++)
        for (int wh = 0; wh < 2; wh++) begin
            logic [7:0] op;
            logic [23:0] a;
            logic [7:0] d;
            logic isw, chip, wrsr, prot, ok, xs, xr;
            logic [7:0] xstat;
            op   = ops[oi];
            a    = {6'b101101, 2'(q), 16'h1234};
            d    = {~1'(sr), 2'b11, ~3'(b), 2'b11};
            isw  = (kind_of(op) != 3'd0);
            chip = (op == 8'hC7) || (op == 8'h60);
            wrsr = (op == 8'h01);
            case (2'(b))
                2'd0: prot = 1'b0;
                2'd1: prot = (q == 3);
                2'd2: prot = (q >= 2);
                default: prot = 1'b1;
            endcase
            ok = (wh == 1) && (wl == 1) &&
                 (wrsr ? !(sr == 1 && wp == 0) : (chip ? (b == 0) : !prot));
            xs = isw && ok;
            xr = isw && !ok;
            setup(1'(sr), 3'(b), 1'(wl));
            wp_n = 1'(wp);
            issue(op, a, d, 1'(wh));
            // R4 R6 R7 R8 R13: accept/reject decisions
            chk("R4/R6/R7/R8 start", op_start, xs);
            chk("R12 reject", cmd_reject, xr);
            if (xs) begin
                chk("R10 kind", op_kind, kind_of(op));
                chk("R10 addr", op_addr, {6'b0, 2'(q), 16'h1234});
                xstat = wrsr ? {~1'(sr), 2'b00, ~3'(b), 2'b11} : {1'(sr), 2'b00, 3'(b), 2'b11};
                chk("R5 status after start", status, xstat);
                pulse_done();
                chk("R11 after done", status, {xstat[7:2], 2'b00});
            end else begin
                chk("R12 status unchanged", status, {1'(sr), 2'b00, 3'(b), 1'(wl), 1'b0});
            end
            @(negedge clk);
            chk("R12 reject one cycle", cmd_reject, 0);
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule